// File: doc/BRIEF.md
# Compare-Output Timer

An 8-bit timer with one compare channel and one waveform pin, programmed over a small register bus of four byte-wide locations. A tick source is chosen by a clock-select field: stopped, a free-running prescaler tapped at one of five ratios, or either edge of an external input that passes through a two-stage synchroniser. Each tick moves the counter according to a 2-bit waveform mode. The mode also decides when the overflow flag is raised and whether the compare register is buffered.

A continuous equality test between the counter and the active compare value drives a match flag and the waveform pin. Both flags can be cleared by software or by acknowledge pulses. Each flag can raise an interrupt request, gated by its own enable and by a global enable input. A force strobe in the control byte acts on the pin as a match would in the non-PWM modes.

Top module: `cmp_out_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, and `wave_out`, `match_irq` and `ovf_irq` are low.
- R2: Control bits [2:0] select the tick: 0 stops the counter, so it holds its value. Codes 1 to 5 tick once every 1, 8, 32, 64 or 256 clocks of a free-running prescaler.
- R3: Clock-select 7 ticks once per rising edge of `ext_tick_in` and 6 ticks once per falling edge, after a two-flop synchroniser.
- R4: Address 1 reads the counter at any time. A write to it sets the counter on the next clock and takes priority over a tick in the same cycle.
- R5: Control bits [4:3] set the mode, and each tick moves the counter. In mode 0 it counts up and wraps 255 to 0. In mode 1 it counts up to 255, then down to 0, and repeats. In mode 2 it clears to 0 when it equals the compare value and otherwise counts up. In mode 3 it counts up and wraps.
- R6: Flag bit 0 at address 3 is set on a tick taken while the counter equals the active compare value. Flag bit 1 is set on a tick taken at 255 in modes 0, 2 and 3, and at 0 in mode 1.
- R7: Writing 1 to a flag bit at address 3 clears that flag, and writing 0 leaves it unchanged. A pulse on `match_ack` or `ovf_ack` clears the matching flag. A set event in the same cycle wins.
- R8: `match_irq` is flag bit 0 AND enable bit 2 AND `glob_irq_en`. `ovf_irq` is flag bit 1 AND enable bit 3 AND `glob_irq_en`.
- R9: A write to address 2 sets the readback value. In modes 0 and 2 it becomes the active compare value at once. In modes 1 and 3 the active value loads from the written value only on a tick taken at 255.
- R10: In modes 0 and 2, on each match tick, control bits [6:5] act on the pin: code 1 toggles it, 2 clears it and 3 sets it. With code 0, `wave_out` is low.
- R11: In mode 3, output code 2 drives the pin high from the tick at 255 until the match tick, which gives compare+1 high ticks in every 256, and code 3 inverts this. In mode 1, code 2 clears the pin on a match while counting up and sets it on a match while counting down, and code 3 inverts this. Output codes 0 and 1 keep the pin low in both PWM modes.
- R12: Writing control bit 7 in modes 0 and 2 acts on the pin once, as a match would, without setting any flag. In modes 1 and 3 it is ignored. Bit 7 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | 0 control, 1 counter, 2 compare, 3 flags and enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_tick_in | input | 1 | External tick source, asynchronous |
| glob_irq_en | input | 1 | Global interrupt enable |
| match_ack | input | 1 | Clears the match flag |
| ovf_ack | input | 1 | Clears the overflow flag |
| wave_out | output | 1 | Waveform pin |
| match_irq | output | 1 | Match interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a compare write made mid-period in a PWM mode. The new value must stay invisible to the pin and the match flag until the counter next passes 255, and in phase-correct mode the counter must also be on the matching slope. The random phase runs every mode at single-clock ticks. During it, stray compare, counter, flag and force writes land at arbitrary counter values, so writes keep falling between load points and on turning points. A bench model follows every cycle of pin, readback and interrupts.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'd0,
        WM_PHASE  = 2'd1,
        WM_CLEAR  = 2'd2,
        WM_FAST   = 2'd3
    } wave_mode_e;

    // packed order matches control byte bits [6:0]
    typedef struct packed {
        logic [1:0] com;
        wave_mode_e mode;
        logic [2:0] csel;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_CMP   = 2'd2;
    localparam logic [1:0] ADDR_FLAGS = 2'd3;

    function automatic logic is_pwm(input wave_mode_e m);
        return (m == WM_PHASE) || (m == WM_FAST);
    endfunction
endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
    parameter int LOG_A = 3,
    parameter int LOG_B = 5,
    parameter int LOG_C = 6,
    parameter int LOG_D = 8,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] csel,
    input  logic       ext_in,
    output logic       tick
);
    localparam int PW = LOG_D;
    localparam int SW = SYNC_N + 1;

    typedef struct packed {
        logic [PW-1:0] presc;
        logic [SW-1:0] sync;
    } tg_state_t;

    tg_state_t s_d, s_q;
    logic ext_rise, ext_fall;

    always_comb begin
        s_d       = s_q;
        s_d.presc = s_q.presc + 1'b1;
        s_d.sync  = {s_q.sync[SW-2:0], ext_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ext_rise = s_q.sync[SW-2] & ~s_q.sync[SW-1];
    assign ext_fall = ~s_q.sync[SW-2] & s_q.sync[SW-1];

    always_comb begin
        unique case (csel)
            3'd1:    tick = 1'b1;
            3'd2:    tick = &s_q.presc[LOG_A-1:0];
            3'd3:    tick = &s_q.presc[LOG_B-1:0];
            3'd4:    tick = &s_q.presc[LOG_C-1:0];
            3'd5:    tick = &s_q.presc[LOG_D-1:0];
            3'd6:    tick = ext_fall;
            3'd7:    tick = ext_rise;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/timer_count_unit.sv
module timer_count_unit
    import timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wave_mode_e   mode,
    input  logic [W-1:0] cmp_act,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         dir_down,
    output logic         at_top,
    output logic         match,
    output logic         ovf_evt,
    output logic         upd_evt
);
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir;
    } cu_state_t;

    cu_state_t s_d, s_q;
    logic at_bot;

    assign at_top = (s_q.cnt == MAXV);
    assign at_bot = (s_q.cnt == '0);
    assign match  = (s_q.cnt == cmp_act);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            unique case (mode)
                WM_PHASE: begin
                    if (!s_q.dir) begin
                        if (at_top) begin
                            s_d.cnt = s_q.cnt - 1'b1;
                            s_d.dir = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else begin
                        if (at_bot) begin
                            s_d.cnt = s_q.cnt + 1'b1;
                            s_d.dir = 1'b0;
                        end else begin
                            s_d.cnt = s_q.cnt - 1'b1;
                        end
                    end
                end
                WM_CLEAR: s_d.cnt = match ? '0 : s_q.cnt + 1'b1;
                default:  s_d.cnt = s_q.cnt + 1'b1;
            endcase
        end
        if (ld_en) begin
            s_d.cnt = ld_val;
            s_d.dir = s_q.dir;
        end
        if (mode != WM_PHASE) s_d.dir = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt      = s_q.cnt;
    assign dir_down = s_q.dir;
    assign ovf_evt  = tick && ((mode == WM_PHASE) ? at_bot : at_top);
    assign upd_evt  = tick && at_top && is_pwm(mode);

    assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (s_q.cnt == $past(ld_val)))
        else $error("counter load lost");

    assert_phase_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && mode == WM_PHASE && !s_q.dir && at_top) |=> s_q.dir)
        else $error("no turn at top");
endmodule

// File: rtl/timer_wave_gen.sv
module timer_wave_gen
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  wave_mode_e mode,
    input  logic [1:0] com,
    input  logic       match,
    input  logic       at_top,
    input  logic       dir_down,
    input  logic       force_hit,
    output logic       wave_out
);
    logic wave_d, wave_q;
    logic pwm;

    assign pwm = is_pwm(mode);

    always_comb begin
        wave_d = wave_q;
        if (!pwm) begin
            if ((tick && match) || force_hit) begin
                unique case (com)
                    2'd1:    wave_d = ~wave_q;
                    2'd2:    wave_d = 1'b0;
                    2'd3:    wave_d = 1'b1;
                    default: wave_d = wave_q;
                endcase
            end
        end else if (com[1] && tick) begin
            if (mode == WM_FAST) begin
                if (at_top)     wave_d = ~com[0];
                else if (match) wave_d = com[0];
            end else if (match) begin
                wave_d = dir_down ^ com[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign wave_out = ((com == 2'd0) || (pwm && com == 2'd1)) ? 1'b0 : wave_q;

    assert_pin_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !force_hit) |=> $stable(wave_q))
        else $error("pin moved without event");
endmodule

// File: rtl/cmp_out_timer.sv
module cmp_out_timer
    import timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         ext_tick_in,
    input  logic         glob_irq_en,
    input  logic         match_ack,
    input  logic         ovf_ack,
    output logic         wave_out,
    output logic         match_irq,
    output logic         ovf_irq
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] cmp_buf;
        logic [W-1:0] cmp_act;
        logic         mflag;
        logic         oflag;
        logic         men;
        logic         oen;
    } top_state_t;

    top_state_t s_d, s_q;

    logic         tick, match, at_top, dir_down, ovf_evt, upd_evt;
    logic         cnt_wr, ctrl_wr, cmp_wr, flag_wr, force_hit;
    logic [W-1:0] cnt;

    assign ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL);
    assign cnt_wr    = bus_wr && (bus_addr == ADDR_COUNT);
    assign cmp_wr    = bus_wr && (bus_addr == ADDR_CMP);
    assign flag_wr   = bus_wr && (bus_addr == ADDR_FLAGS);
    assign force_hit = ctrl_wr && bus_wdata[7] && !is_pwm(s_q.ctrl.mode);

    timer_tick_gen u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .csel   (s_q.ctrl.csel),
        .ext_in (ext_tick_in),
        .tick   (tick)
    );

    timer_count_unit #(.W(W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (s_q.ctrl.mode),
        .cmp_act  (s_q.cmp_act),
        .ld_en    (cnt_wr),
        .ld_val   (bus_wdata),
        .cnt      (cnt),
        .dir_down (dir_down),
        .at_top   (at_top),
        .match    (match),
        .ovf_evt  (ovf_evt),
        .upd_evt  (upd_evt)
    );

    timer_wave_gen u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (s_q.ctrl.mode),
        .com       (s_q.ctrl.com),
        .match     (match),
        .at_top    (at_top),
        .dir_down  (dir_down),
        .force_hit (force_hit),
        .wave_out  (wave_out)
    );

    always_comb begin
        s_d = s_q;
        if (ctrl_wr) s_d.ctrl    = ctrl_t'(bus_wdata[6:0]);
        if (cmp_wr)  s_d.cmp_buf = bus_wdata;
        if (is_pwm(s_q.ctrl.mode)) begin
            if (upd_evt) s_d.cmp_act = s_q.cmp_buf;
        end else begin
            s_d.cmp_act = s_d.cmp_buf;
        end
        s_d.mflag = (s_q.mflag && !((flag_wr && bus_wdata[0]) || match_ack))
                    || (tick && match);
        s_d.oflag = (s_q.oflag && !((flag_wr && bus_wdata[1]) || ovf_ack))
                    || ovf_evt;
        if (flag_wr) begin
            s_d.men = bus_wdata[2];
            s_d.oen = bus_wdata[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:  bus_rdata = {1'b0, s_q.ctrl};
            ADDR_COUNT: bus_rdata = cnt;
            ADDR_CMP:   bus_rdata = s_q.cmp_buf;
            default:    bus_rdata = {{(W-4){1'b0}}, s_q.oen, s_q.men, s_q.oflag, s_q.mflag};
        endcase
    end

    assign match_irq = s_q.mflag && s_q.men && glob_irq_en;
    assign ovf_irq   = s_q.oflag && s_q.oen && glob_irq_en;

    assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match) |=> s_q.mflag)
        else $error("match flag missed");

    assert_ovf_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> s_q.oflag)
        else $error("overflow flag missed");

    assert_buffer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(s_q.ctrl.mode) && !upd_evt) |=> $stable(s_q.cmp_act))
        else $error("active compare changed between loads");

    assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.csel == 3'd0 && !cnt_wr) |=> $stable(cnt))
        else $error("counter moved while stopped");
endmodule

// File: tb/cmp_out_timer_bench.sv
module cmp_out_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_tick_in = 1'b0;
    logic       glob_irq_en = 1'b0;
    logic       match_ack = 1'b0;
    logic       ovf_ack = 1'b0;
    logic       wave_out, match_irq, ovf_irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    cmp_out_timer u_cmp_out_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick_in(ext_tick_in),
        .glob_irq_en(glob_irq_en), .match_ack(match_ack), .ovf_ack(ovf_ack),
        .wave_out(wave_out), .match_irq(match_irq), .ovf_irq(ovf_irq)
    );

    // reference model state (valid while clock select is 0 or 1)
    logic [7:0] m_cnt = 0, m_act = 0, m_buf = 0;
    logic [2:0] m_cs = 0;
    logic [1:0] m_mode = 0, m_com = 0;
    bit m_dir = 0, m_mf = 0, m_of = 0, m_men = 0, m_oen = 0, m_wq = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {1'b0, m_com, m_mode, m_cs};
            2'd1:    return m_cnt;
            2'd2:    return m_buf;
            default: return {4'd0, m_oen, m_men, m_of, m_mf};
        endcase
    endfunction

    function automatic bit m_pin();
        bit pwm = (m_mode == 2'd1) || (m_mode == 2'd3);
        if (m_com == 2'd0 || (pwm && m_com == 2'd1)) return 1'b0;
        return m_wq;
    endfunction

    // one clock: model next state from current inputs, then advance
    task automatic cyc();
        bit tick = (m_cs == 3'd1);
        bit pwm = (m_mode == 2'd1) || (m_mode == 2'd3);
        bit match = (m_cnt == m_act);
        bit ovf = 0, upd = 0, ev, clr;
        logic [7:0] n_cnt = m_cnt, n_act = m_act, n_buf = m_buf;
        logic [2:0] n_cs = m_cs;
        logic [1:0] n_mode = m_mode, n_com = m_com;
        bit n_dir = m_dir, n_mf, n_of, n_men = m_men, n_oen = m_oen, n_wq = m_wq;
        if (tick) begin
            case (m_mode)
                2'd0: begin n_cnt = m_cnt + 1; ovf = (m_cnt == 8'hFF); end
                2'd1: begin
                    ovf = (m_cnt == 8'h00); upd = (m_cnt == 8'hFF);
                    if (!m_dir) begin
                        if (m_cnt == 8'hFF) begin n_cnt = 8'hFE; n_dir = 1; end
                        else n_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 8'h00) begin n_cnt = 8'h01; n_dir = 0; end
                        else n_cnt = m_cnt - 1;
                    end
                end
                2'd2: begin n_cnt = match ? 8'h00 : m_cnt + 1; ovf = (m_cnt == 8'hFF); end
                default: begin n_cnt = m_cnt + 1; ovf = (m_cnt == 8'hFF); upd = ovf; end
            endcase
        end
        ev = (tick && match) || (bus_wr && bus_addr == 2'd0 && bus_wdata[7] && !pwm);
        if (!pwm) begin
            if (ev) case (m_com)
                2'd1: n_wq = !m_wq;
                2'd2: n_wq = 0;
                2'd3: n_wq = 1;
                default: ;
            endcase
        end else if (tick && m_com >= 2'd2) begin
            if (m_mode == 2'd3) begin
                if (m_cnt == 8'hFF) n_wq = (m_com == 2'd2);
                else if (match)     n_wq = (m_com == 2'd3);
            end else if (match) begin
                n_wq = (m_com == 2'd2) ? m_dir : !m_dir;
            end
        end
        if (bus_wr && bus_addr == 2'd1) begin n_cnt = bus_wdata; n_dir = m_dir; end
        if (m_mode != 2'd1) n_dir = 0;
        if (bus_wr && bus_addr == 2'd2) n_buf = bus_wdata;
        n_act = pwm ? (upd ? m_buf : m_act) : n_buf;
        clr = (bus_wr && bus_addr == 2'd3 && bus_wdata[0]) || match_ack;
        n_mf = (m_mf && !clr) || (tick && match);
        clr = (bus_wr && bus_addr == 2'd3 && bus_wdata[1]) || ovf_ack;
        n_of = (m_of && !clr) || ovf;
        if (bus_wr && bus_addr == 2'd3) begin n_men = bus_wdata[2]; n_oen = bus_wdata[3]; end
        if (bus_wr && bus_addr == 2'd0) begin
            n_cs = bus_wdata[2:0]; n_mode = bus_wdata[4:3]; n_com = bus_wdata[6:5];
        end
        @(posedge clk);
        m_cnt = n_cnt; m_act = n_act; m_buf = n_buf; m_cs = n_cs; m_mode = n_mode;
        m_com = n_com; m_dir = n_dir; m_mf = n_mf; m_of = n_of; m_men = n_men;
        m_oen = n_oen; m_wq = n_wq;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 0;
    endtask

    function automatic logic [7:0] ctrl_byte(input bit frc, input int com, input int mode, input int cs);
        return {frc, com[1:0], mode[1:0], cs[2:0]};
    endfunction

    function automatic string pin_req(input logic [1:0] mode);
        return (mode == 2'd1 || mode == 2'd3) ? "R11" : "R10";
    endfunction

    task automatic compare_all();
        chk(bus_rdata == m_read(bus_addr),
            (bus_addr == 2'd1) ? "R5" : (bus_addr == 2'd3) ? "R6" : "R9",
            bus_rdata, m_read(bus_addr));
        chk(wave_out == m_pin(), pin_req(m_mode), wave_out, m_pin());
        chk(match_irq == (m_mf && m_men && glob_irq_en), "R8", match_irq, m_mf && m_men && glob_irq_en);
        chk(ovf_irq == (m_of && m_oen && glob_irq_en), "R8", ovf_irq, m_of && m_oen && glob_irq_en);
    endtask

    task automatic read_cnt(output logic [7:0] v);
        bus_addr = 2'd1;
        #1 v = bus_rdata;
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int unsigned seed = 32'h5EED_7110;
        logic [7:0] v0, v1;
        int hi;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_addr = a[1:0];
            #1 chk(bus_rdata == 8'h00, "R1", bus_rdata, 0);
        end
        chk(wave_out == 0 && match_irq == 0 && ovf_irq == 0, "R1",
            {wave_out, match_irq, ovf_irq}, 0);
        rst_n = 1;
        @(negedge clk);

        // random rounds: every mode/output code at single-clock ticks
        for (int r = 0; r < 16; r++) begin
            int mode = $urandom_range(3);
            int com = $urandom_range(3);
            bus_write(2'd0, ctrl_byte(0, com, mode, 0));
            compare_all();
            bus_write(2'd2, 8'($urandom_range(255)));
            bus_write(2'd1, 8'($urandom_range(255)));
            bus_write(2'd3, 8'h03 | 8'($urandom_range(3) << 2));
            bus_write(2'd0, ctrl_byte($urandom_range(1), com, mode, 1));
            compare_all();
            for (int c = 0; c < 600; c++) begin
                int p = $urandom_range(63);
                bus_addr = 2'($urandom_range(3));
                glob_irq_en = $urandom_range(1);
                match_ack = ($urandom_range(15) == 0);
                ovf_ack = ($urandom_range(15) == 0);
                if (p == 0)      begin bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'($urandom_range(255)); end
                else if (p == 1) begin bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'($urandom_range(255)); end
                else if (p == 2) begin bus_wr = 1; bus_addr = 2'd3; bus_wdata = 8'($urandom_range(15)); end
                else if (p == 3) begin bus_wr = 1; bus_addr = 2'd0; bus_wdata = ctrl_byte(1, com, mode, 1); end
                cyc();
                bus_wr = 0; match_ack = 0; ovf_ack = 0;
                compare_all();
            end
        end

        // R7 directed: zero write leaves flags, one write clears
        bus_write(2'd0, ctrl_byte(0, 0, 0, 0));
        bus_write(2'd1, 8'h05);
        bus_write(2'd2, 8'h05);
        bus_write(2'd0, ctrl_byte(0, 0, 0, 1));
        bus_write(2'd0, ctrl_byte(0, 0, 0, 0));
        bus_addr = 2'd3;
        #1 chk(bus_rdata[0] == 1, "R6", bus_rdata, 1);
        bus_write(2'd3, 8'h00);
        #1 chk(bus_rdata[0] == 1, "R7", bus_rdata, 1);
        bus_write(2'd3, 8'h01);
        #1 chk(bus_rdata[0] == 0, "R7", bus_rdata, 0);

        // R12 force bit reads back as zero
        bus_write(2'd0, ctrl_byte(1, 1, 0, 0));
        bus_addr = 2'd0;
        #1 chk(bus_rdata == 8'h20, "R12", bus_rdata, 8'h20);

        // R4 write while stopped and while counting
        bus_write(2'd1, 8'h5A);
        #1 chk(bus_rdata == 8'h5A, "R4", bus_rdata, 8'h5A);
        bus_write(2'd0, ctrl_byte(0, 0, 0, 1));
        bus_write(2'd1, 8'h10);
        #1 chk(bus_rdata == 8'h10, "R4", bus_rdata, 8'h10);

        // R11 fast PWM duty: compare 63 gives 64 high ticks per 256
        bus_write(2'd2, 8'd63);
        bus_write(2'd0, ctrl_byte(0, 2, 3, 1));
        repeat (300) cyc();
        hi = 0;
        for (int c = 0; c < 256; c++) begin
            hi += wave_out;
            cyc();
        end
        chk(hi == 64, "R11", hi, 64);

        // R2 prescaler ratios and stop
        begin
            int cs_tab[5] = '{0, 2, 3, 4, 5};
            int win[5] = '{50, 64, 128, 128, 512};
            int exp_d[5] = '{0, 8, 4, 2, 2};
            for (int k = 0; k < 5; k++) begin
                bus_write(2'd0, ctrl_byte(0, 0, 0, cs_tab[k]));
                read_cnt(v0);
                repeat (win[k]) @(negedge clk);
                read_cnt(v1);
                chk(8'(v1 - v0) == exp_d[k], "R2", 8'(v1 - v0), exp_d[k]);
            end
        end

        // R3 external edges, rising then falling
        for (int k = 0; k < 2; k++) begin
            bus_write(2'd0, ctrl_byte(0, 0, 0, (k == 0) ? 7 : 6));
            repeat (4) @(negedge clk);
            read_cnt(v0);
            for (int e = 0; e < 6; e++) begin
                ext_tick_in = 1; repeat (4) @(negedge clk);
                ext_tick_in = 0; repeat (4) @(negedge clk);
            end
            repeat (6) @(negedge clk);
            read_cnt(v1);
            chk(8'(v1 - v0) == 6, "R3", 8'(v1 - v0), 6);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule